// File: doc/BRIEF.md
# Dual-oscillator OR-combined pulse generator

The block turns one frequency word into a one-bit pulse train whose duty cycle is set by a phase word. Two phase accumulators of equal width advance by the same frequency word on every clock. The top bit of each accumulator is brought out as a square wave. The OR of the two square waves is the pulse output. Because both oscillators run at the same rate, their phase gap stays fixed between loads. That gap sets the duty cycle of the OR, anywhere from one half (zero gap) up to a steady high (gap of half a turn). The strength of the fundamental follows the duty cycle.

Neither accumulator is cleared when it wraps or when its output toggles. Whatever is left over after a wrap carries into the next period. So when the frequency word is not a power of two, successive periods differ by a clock, while the long-run frequency stays exact to one part in 2^ACC_W of the clock. A single load strobe takes the frequency and phase words. It moves the leading accumulator forward by the new frequency word and places the lagging accumulator at that same value plus the phase word, in the same edge. A small controller holds the oscillators in a halted state when no frequency is set or the frequency word loaded is zero, and in a running state otherwise.

Controller states: `ST_HALT` (accumulators hold) and `ST_RUN` (accumulators advance). Transitions: T_RESET (reset to `ST_HALT`), T_START (a load with a nonzero word goes to `ST_RUN`), T_PARK (a load with a zero word goes to `ST_HALT`). Without a load, the controller stays in its current state.

Top module: `dual_nco_pwm`

## Requirements
- R1: While `rst` is high at a rising edge, both accumulators are cleared to zero and the controller enters `ST_HALT`, so `lead_out`, `lag_out` and `pulse_out` are all 0 after that edge.
- R2: In `ST_RUN` without a load, each accumulator adds the stored frequency word (modulo 2^ACC_W) at every edge. `lead_out` and `lag_out` are bit ACC_W-1 of the leading and lagging accumulator.
- R3: A load is seen at the next rising edge. At that edge the leading accumulator becomes its old value plus the new `freq_word`, and that word is stored for later steps.
- R4: At the edge of a load, the lagging accumulator becomes the new leading value plus `phase_word` (modulo 2^ACC_W).
- R5: An accumulator is never reset on a wrap or an output edge. With a frequency word of 3·2^(ACC_W-4) and the accumulator at zero before the load, the output after the k-th edge is 1 exactly when (3k mod 16) ≥ 8. That gives 8 high samples in every 16 clocks. With a word of 4·2^(ACC_W-4), the output repeats 0,1,1,0 from the load edge on.
- R6: A zero frequency word parks the controller in `ST_HALT`, and both outputs hold their values until the next load or reset.
- R7: `pulse_out` is the OR of the two oscillator outputs. For a period of 256 clocks, a phase word of 0 gives 128 high clocks per period, a quarter turn (2^(ACC_W-2)) gives 192, and a half turn (2^(ACC_W-1)) gives 256.
- R8: Between loads the difference lagging minus leading accumulator stays constant and equal to the last phase word loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | ACC_W | Per-clock phase increment, taken on a load |
| phase_word | input | ACC_W | Lag of the second oscillator behind the first... placed ahead by this amount, taken on a load |
| load | input | 1 | Strobe that takes both words at the next rising edge |
| lead_out | output | 1 | Top bit of the leading accumulator |
| lag_out | output | 1 | Top bit of the lagging accumulator |
| pulse_out | output | 1 | OR of the two oscillator outputs |

## Verification
The assertions check the cycle-level rules at every edge. They cover the clear on reset, the advance by the stored word while running, the advance by the fresh word and the placement of the lagging accumulator on a load, the hold while halted, and the constant gap between the two accumulators when no load occurs. Some behaviours need many cycles and show only in the bench's scenarios: the uneven run lengths from carried residue, the repeating pattern for a power-of-two increment, and the high-time counts that set the duty cycle for a given phase word.

// File: rtl/dnco_pkg.sv
package dnco_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } dnco_state_e;

    localparam int unsigned LANE_COUNT = 2;

endpackage

// File: rtl/dnco_ctrl.sv
module dnco_ctrl
    import dnco_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] freq_word,
    output logic         run,
    output logic [W-1:0] freq_q
);

    dnco_state_e state_q;
    dnco_state_e state_d;

    // next-state: T_START on a nonzero load, T_PARK on a zero load
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (load && (freq_word != '0)) state_d = ST_RUN;
            ST_RUN:  if (load && (freq_word == '0)) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // state register; T_RESET forces ST_HALT
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HALT;
            freq_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) freq_q <= freq_word;
        end
    end

    // outputs of the controller
    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            ST_HALT: run = 1'b0;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/dnco_lane.sv
module dnco_lane #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] inc,
    input  logic         preset_en,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] acc,
    output logic         msb
);

    localparam int unsigned TOP = W - 1;

    // the residue after a wrap is kept: no clear on rollover
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (preset_en) begin
            acc <= preset_val;
        end else if (step) begin
            acc <= acc + inc;
        end
    end

    assign msb = acc[TOP];

endmodule

// File: rtl/dual_nco_pwm.sv
module dual_nco_pwm
    import dnco_pkg::*;
#(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [ACC_W-1:0] phase_word,
    input  logic             load,
    output logic             lead_out,
    output logic             lag_out,
    output logic             pulse_out
);

    logic             run;
    logic [ACC_W-1:0] freq_q;
    logic [ACC_W-1:0] base_next;
    logic [ACC_W-1:0] acc_lane [LANE_COUNT];
    logic             msb_lane [LANE_COUNT];
    logic [ACC_W-1:0] acc_lead;
    logic [ACC_W-1:0] acc_lag;

    dnco_ctrl #(.W(ACC_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .freq_word (freq_word),
        .run       (run),
        .freq_q    (freq_q)
    );

    // leading accumulator advanced by the fresh word on a load
    assign base_next = acc_lane[0] + freq_word;

    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        logic [ACC_W-1:0] offs;
        if (g == 0) begin : g_ref
            assign offs = '0;
        end else begin : g_off
            assign offs = phase_word;
        end
        dnco_lane #(.W(ACC_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .step       (run),
            .inc        (freq_q),
            .preset_en  (load),
            .preset_val (base_next + offs),
            .acc        (acc_lane[g]),
            .msb        (msb_lane[g])
        );
    end

    assign acc_lead  = acc_lane[0];
    assign acc_lag   = acc_lane[1];
    assign lead_out  = msb_lane[0];
    assign lag_out   = msb_lane[1];
    assign pulse_out = msb_lane[0] | msb_lane[1];

endmodule

// File: rtl/dnco_checker.sv
module dnco_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic [W-1:0] freq_word,
    input logic [W-1:0] phase_word,
    input logic         run,
    input logic [W-1:0] freq_q,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] acc_b,
    input logic         lead_out,
    input logic         lag_out,
    input logic         pulse_out
);

    logic [W-1:0] gap;
    assign gap = acc_b - acc_a;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_a == '0) && (acc_b == '0) && !pulse_out);

    a_r2_run_step: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> (acc_a == $past(acc_a) + $past(freq_q)));

    a_r3_load_advance: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_a == $past(acc_a) + $past(freq_word)));

    a_r4_load_offset: assert property (@(posedge clk) disable iff (rst)
        load |=> (gap == $past(phase_word)));

    a_r6_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> ($stable(lead_out) && $stable(lag_out)));

    a_r7_pulse_low: assert property (@(posedge clk) disable iff (rst)
        !pulse_out |-> (!lead_out && !lag_out));

    a_r8_gap_locked: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(gap));

endmodule

bind dual_nco_pwm dnco_checker #(.W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .freq_word  (freq_word),
    .phase_word (phase_word),
    .run        (run),
    .freq_q     (freq_q),
    .acc_a      (acc_lead),
    .acc_b      (acc_lag),
    .lead_out   (lead_out),
    .lag_out    (lag_out),
    .pulse_out  (pulse_out)
);

// File: tb/test_dual_nco_pwm.sv
module test_dual_nco_pwm;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] freq_word = '0;
    logic [W-1:0] phase_word = '0;
    logic         load = 1'b0;
    logic         lead_out, lag_out, pulse_out;

    int total = 0;
    int fails = 0;

    // reference state computed from R2..R4 and R6
    logic [W-1:0] m_a = '0, m_b = '0, m_f = '0;
    logic         m_run = 1'b0;

    always #5 clk = ~clk;

    dual_nco_pwm #(.ACC_W(W)) i_dual_nco_pwm (
        .clk, .rst, .freq_word, .phase_word, .load,
        .lead_out, .lag_out, .pulse_out
    );

    // vectors: {freq, phase, cycles}
    localparam int NV = 5;
    localparam logic [79:0] VEC [NV] = '{
        {32'h0123_4567, 32'h4000_0000, 16'd300},
        {32'h0048_D15A, 32'h2000_0000, 16'd1000},
        {32'hFFFF_FFFF, 32'h0000_0001, 16'd50},
        {32'h8000_0000, 32'hC000_0000, 16'd20},
        {32'h0000_0000, 32'h9000_0000, 16'd30}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, settle
    task automatic tick(input bit r, input bit ld, input logic [W-1:0] fw, input logic [W-1:0] pw);
        @(negedge clk);
        rst = r; load = ld; freq_word = fw; phase_word = pw;
        @(posedge clk);
        if (r) begin
            m_a = '0; m_b = '0; m_f = '0; m_run = 1'b0;
        end else if (ld) begin
            m_a = m_a + fw; m_b = m_a + pw; m_f = fw; m_run = (fw != '0);
        end else if (m_run) begin
            m_a = m_a + m_f; m_b = m_b + m_f;
        end
        #1;
    endtask

    function automatic bit model_ok();
        return (lead_out == m_a[W-1]) && (lag_out == m_b[W-1])
            && (pulse_out == (m_a[W-1] | m_b[W-1]));
    endfunction

    task automatic idle(input int n, output int bad, output int highs);
        bad = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 1'b0, '0, '0);
            if (!model_ok()) bad++;
            if (pulse_out) highs++;
        end
    endtask

    initial begin
        int bad, highs;
        logic [3:0] k4;
        tick(1'b1, 1'b0, '0, '0);
        tick(1'b1, 1'b0, '0, '0);
        // R1: reset state
        check({lead_out, lag_out, pulse_out} == 3'b000, "R1 reset outputs", {lead_out, lag_out, pulse_out}, 0);

        // table walk: R2, R4, R8 against the reference model
        for (int v = 0; v < NV; v++) begin
            tick(1'b0, 1'b1, VEC[v][79:48], VEC[v][47:16]);
            bad = model_ok() ? 0 : 1;
            begin
                int b2, h2;
                idle(int'(VEC[v][15:0]), b2, h2);
                bad += b2;
            end
            check(bad == 0, $sformatf("R2/R8 vector %0d mismatches", v), bad, 0);
        end

        // R1: reset in the middle of a run
        tick(1'b0, 1'b1, 32'h1234_5679, 32'h8000_0000);
        tick(1'b1, 1'b0, '0, '0);
        check(pulse_out == 1'b0, "R1 mid-run reset", pulse_out, 0);

        // R3: load takes effect at the next edge
        tick(1'b0, 1'b1, 32'h8000_0000, '0);
        check(lead_out == 1'b1, "R3 first edge after load", lead_out, 1);
        tick(1'b0, 1'b0, '0, '0);
        check(lead_out == 1'b0, "R3 stored word wraps", lead_out, 0);

        // R4 and R6: zero word, half-turn offset, frozen
        tick(1'b1, 1'b0, '0, '0);
        tick(1'b0, 1'b1, '0, 32'h8000_0000);
        check({lead_out, lag_out} == 2'b01, "R4 lag placed by offset", {lead_out, lag_out}, 1);
        idle(10, bad, highs);
        check({lead_out, lag_out} == 2'b01 && highs == 10, "R6 halted outputs hold", highs, 10);

        // R5: increment 3/16 of a turn, residue carried
        tick(1'b1, 1'b0, '0, '0);
        bad = 0; highs = 0;
        for (int k = 1; k <= 16; k++) begin
            if (k == 1) tick(1'b0, 1'b1, 32'h3000_0000, '0);
            else        tick(1'b0, 1'b0, '0, '0);
            k4 = 4'(3 * k);
            if (lead_out != (k4 >= 4'd8)) bad++;
            if (lead_out) highs++;
        end
        check(bad == 0, "R5 uneven run pattern", bad, 0);
        check(highs == 8, "R5 highs per 16 clocks", highs, 8);

        // R5: power-of-two increment gives 0,1,1,0
        tick(1'b1, 1'b0, '0, '0);
        bad = 0;
        for (int k = 1; k <= 12; k++) begin
            if (k == 1) tick(1'b0, 1'b1, 32'h4000_0000, '0);
            else        tick(1'b0, 1'b0, '0, '0);
            if (lead_out != ((k % 4) == 2 || (k % 4) == 3)) bad++;
        end
        check(bad == 0, "R5 steady 0110 pattern", bad, 0);

        // R7: duty from phase gap, period 256
        tick(1'b1, 1'b0, '0, '0);
        tick(1'b0, 1'b1, 32'h0100_0000, 32'h0000_0000);
        idle(256, bad, highs);
        check(highs == 128, "R7 zero gap duty", highs, 128);
        tick(1'b0, 1'b1, 32'h0100_0000, 32'h4000_0000);
        idle(256, bad, highs);
        check(highs == 192, "R7 quarter gap duty", highs, 192);
        tick(1'b0, 1'b1, 32'h0100_0000, 32'h8000_0000);
        idle(256, bad, highs);
        check(highs == 256, "R7 half gap duty", highs, 256);
        check(bad == 0, "R8 lanes locked after reload", bad, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog R1..R8 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule